// File: doc/BRIEF.md
# Multi-Mode Quadrature Position Counter

This block tracks shaft position from an incremental encoder's two channels, A and B. A 2-bit mode field chooses how edges become counts:
- Quadrature x4 decoding, with the direction taken from the phase order.
- Pulse/direction, where A is the clock and B gives the direction.
- Up-only or down-only, where A is the clock and B is ignored.

Both inputs pass through a two-flop synchronizer before edge detection, so they may be asynchronous to the block clock.

The count runs between zero and a programmable maximum and wraps at either end. A wrap upward raises an overflow flag and a wrap downward raises an underflow flag. Each flag has its own interrupt enable. When an event sets a flag whose enable is on, a global interrupt flag is set, and this flag drives the interrupt output. Software writes the count, the maximum, the control word, the enables and a write-one-to-clear word through a simple write port.

Top module: `qpc_top`

## Requirements
- R1: After reset the count is 0, all flags are 0, irq_o is 0 and the maximum is all ones.
- R2: Register addresses are 0 = count, 1 = maximum, 2 = control, 3 = interrupt enable and 4 = clear. In the control word, bits [1:0] are the mode, bit 2 is the edge rate and bit 3 is the enable. With mode 0 (quadrature), each single change of A or B moves the count by one. The sequence {A,B} = 00,10,11,01 counts up and the reverse sequence counts down.
- R3: In quadrature mode, a synchronized sample in which A and B both change leaves the count unchanged.
- R4: In mode 1 (pulse/direction), only rising edges of A count. The count goes up when B is 1 and down when B is 0.
- R5: Mode 2 counts up and mode 3 counts down, on A only. A rising edge of A always counts. A falling edge of A counts only when the edge-rate bit is 1. Changes on B have no effect in these modes.
- R6: With the enable bit 0, edges do not change the count.
- R7: A count up from a value at or above the maximum gives 0 and sets the overflow flag (flags_o bit 6).
- R8: A count down from 0 gives the maximum and sets the underflow flag (flags_o bit 5).
- R9: A count write with a value at or below the maximum loads that value. A count write above the maximum is rejected, and the count holds for that cycle.
- R10: The global flag (flags_o bit 0) sets when an event occurs whose enable bit is 1. The enable bits sit at bit 6 (overflow) and bit 5 (underflow) of the enable word. irq_o equals the global flag. An event whose enable is 0 sets only its own flag.
- R11: Writing 1 to bit 6, 5 or 0 of the clear word clears the matching flag. A new event in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| enc_a_i | input | 1 | Encoder channel A, asynchronous |
| enc_b_i | input | 1 | Encoder channel B, asynchronous |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register select |
| wr_data_i | input | 32 | Write data |
| count_o | output | 32 | Current position count |
| flags_o | output | 7 | Flags: bit 6 overflow, bit 5 underflow, bit 0 global |
| irq_o | output | 1 | Interrupt output |

## Verification
The assertions check on every cycle the rules that hold at all times:
- An illegal double change in quadrature mode, or a change on B in an A-only mode, never produces a step.
- An overflow event always lands the count on zero, and an underflow event always lands it on the maximum.
- A rejected count write leaves the count unchanged.
- Every event is recorded in its flag.
- The global flag rises only after an enabled event.

Only the bench's scenarios can show the rest. These are the actual count sequences in each mode, the effect of the edge-rate bit, the gating by the enable bit, the reset value of the maximum (reached by an underflow from reset), and the precedence of write-one-to-clear against pending flags.

// File: rtl/qpc_pkg.sv
package qpc_pkg;
  typedef enum logic [1:0] {
    MODE_QUAD = 2'd0,
    MODE_PDIR = 2'd1,
    MODE_UP   = 2'd2,
    MODE_DOWN = 2'd3
  } qpc_mode_e;

  localparam logic [2:0] ADDR_CNT  = 3'd0;
  localparam logic [2:0] ADDR_MAX  = 3'd1;
  localparam logic [2:0] ADDR_CTRL = 3'd2;
  localparam logic [2:0] ADDR_IE   = 3'd3;
  localparam logic [2:0] ADDR_CLR  = 3'd4;

  localparam int CTRL_RATE_BIT = 2;
  localparam int CTRL_EN_BIT   = 3;
  localparam int OVF_BIT       = 6;
  localparam int UNF_BIT       = 5;
  localparam int GLB_BIT       = 0;
  localparam int FLAG_W        = 7;
endpackage

// File: rtl/qpc_sync.sv
module qpc_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [1:0] stg_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q <= '0;
      else         stg_q <= {stg_q[0], d_i[i]};
    end
    assign q_o[i] = stg_q[1];
  end
endmodule

// File: rtl/qpc_decode.sv
module qpc_decode
  import qpc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      a_i,
  input  logic      b_i,
  input  qpc_mode_e mode_i,
  input  logic      rate_both_i,
  output logic      step_o,
  output logic      up_o
);
  logic a_q, b_q, a_chg, b_chg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= 1'b0;
      b_q <= 1'b0;
    end else begin
      a_q <= a_i;
      b_q <= b_i;
    end
  end

  assign a_chg = a_i ^ a_q;
  assign b_chg = b_i ^ b_q;

  always_comb begin
    step_o = 1'b0;
    up_o   = 1'b1;
    unique case (mode_i)
      MODE_QUAD: begin
        step_o = a_chg ^ b_chg;   // exactly one input moved
        up_o   = a_i ^ b_q;       // A leading B counts up
      end
      MODE_PDIR: begin
        step_o = a_chg & a_i;
        up_o   = b_i;
      end
      MODE_UP: begin
        step_o = a_chg & (a_i | rate_both_i);
        up_o   = 1'b1;
      end
      MODE_DOWN: begin
        step_o = a_chg & (a_i | rate_both_i);
        up_o   = 1'b0;
      end
      default: ;
    endcase
  end

  p_illegal_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == MODE_QUAD && a_chg && b_chg) |-> !step_o);

  p_b_ignored_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((mode_i == MODE_UP || mode_i == MODE_DOWN) && !a_chg) |-> !step_o);
endmodule

// File: rtl/qpc_counter.sv
module qpc_counter #(
  parameter int          CNT_W     = 32,
  parameter logic [CNT_W-1:0] RESET_MAX = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             step_i,
  input  logic             up_i,
  input  logic             wr_cnt_i,
  input  logic             wr_max_i,
  input  logic [CNT_W-1:0] wr_data_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o,
  output logic             unf_o
);
  logic [CNT_W-1:0] cnt_q, max_q;
  logic             wr_ok;

  assign wr_ok = wr_data_i <= max_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
    end else begin
      ovf_o <= 1'b0;
      unf_o <= 1'b0;
      if (wr_cnt_i) begin
        if (wr_ok) cnt_q <= wr_data_i;   // rejected write holds the count
      end else if (en_i && step_i) begin
        if (up_i) begin
          if (cnt_q >= max_q) begin
            cnt_q <= '0;
            ovf_o <= 1'b1;
          end else cnt_q <= cnt_q + 1'b1;
        end else begin
          if (cnt_q == '0) begin
            cnt_q <= max_q;
            unf_o <= 1'b1;
          end else cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       max_q <= RESET_MAX;
    else if (wr_max_i) max_q <= wr_data_i;
  end

  assign cnt_o = cnt_q;

  p_ovf_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> cnt_q == '0);

  p_unf_max_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_o |-> cnt_q == $past(max_q));

  p_reject_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_cnt_i && wr_data_i > max_q) |=> cnt_q == $past(cnt_q));
endmodule

// File: rtl/qpc_irq.sv
module qpc_irq
  import qpc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ovf_evt_i,
  input  logic              unf_evt_i,
  input  logic              wr_ie_i,
  input  logic              wr_clr_i,
  input  logic [FLAG_W-1:0] wr_data_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  logic ie_ovf_q, ie_unf_q, ovf_q, unf_q, glb_q;
  logic clr_ovf, clr_unf, clr_glb, glb_set;

  assign clr_ovf = wr_clr_i & wr_data_i[OVF_BIT];
  assign clr_unf = wr_clr_i & wr_data_i[UNF_BIT];
  assign clr_glb = wr_clr_i & wr_data_i[GLB_BIT];
  assign glb_set = (ovf_evt_i & ie_ovf_q) | (unf_evt_i & ie_unf_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_ovf_q <= 1'b0;
      ie_unf_q <= 1'b0;
      ovf_q    <= 1'b0;
      unf_q    <= 1'b0;
      glb_q    <= 1'b0;
    end else begin
      if (wr_ie_i) begin
        ie_ovf_q <= wr_data_i[OVF_BIT];
        ie_unf_q <= wr_data_i[UNF_BIT];
      end
      ovf_q <= ovf_evt_i | (ovf_q & ~clr_ovf);
      unf_q <= unf_evt_i | (unf_q & ~clr_unf);
      glb_q <= glb_set   | (glb_q & ~clr_glb);
    end
  end

  always_comb begin
    flags_o          = '0;
    flags_o[OVF_BIT] = ovf_q;
    flags_o[UNF_BIT] = unf_q;
    flags_o[GLB_BIT] = glb_q;
  end
  assign irq_o = glb_q;

  p_ovf_flag_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_evt_i |=> ovf_q);

  p_unf_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unf_evt_i |=> unf_q);

  p_glb_cause_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(glb_q) |-> $past((ovf_evt_i & ie_ovf_q) | (unf_evt_i & ie_unf_q)));

  p_clear_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_ovf && !ovf_evt_i) |=> !ovf_q);
endmodule

// File: rtl/qpc_top.sv
module qpc_top
  import qpc_pkg::*;
#(
  parameter int               CNT_W     = 32,
  parameter logic [CNT_W-1:0] RESET_MAX = '1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enc_a_i,
  input  logic              enc_b_i,
  input  logic              wr_en_i,
  input  logic [2:0]        wr_addr_i,
  input  logic [CNT_W-1:0]  wr_data_i,
  output logic [CNT_W-1:0]  count_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              irq_o
);
  logic [1:0] enc_s;
  logic [1:0] mode_q;
  logic       rate_q, en_q;
  logic       step, up, ovf, unf;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= 2'd0;
      rate_q <= 1'b0;
      en_q   <= 1'b0;
    end else if (wr_en_i && wr_addr_i == ADDR_CTRL) begin
      mode_q <= wr_data_i[1:0];
      rate_q <= wr_data_i[CTRL_RATE_BIT];
      en_q   <= wr_data_i[CTRL_EN_BIT];
    end
  end

  qpc_sync #(.W(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({enc_b_i, enc_a_i}),
    .q_o   (enc_s)
  );

  qpc_decode u_dec (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .a_i        (enc_s[0]),
    .b_i        (enc_s[1]),
    .mode_i     (qpc_mode_e'(mode_q)),
    .rate_both_i(rate_q),
    .step_o     (step),
    .up_o       (up)
  );

  qpc_counter #(.CNT_W(CNT_W), .RESET_MAX(RESET_MAX)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en_q),
    .step_i   (step),
    .up_i     (up),
    .wr_cnt_i (wr_en_i && wr_addr_i == ADDR_CNT),
    .wr_max_i (wr_en_i && wr_addr_i == ADDR_MAX),
    .wr_data_i(wr_data_i),
    .cnt_o    (count_o),
    .ovf_o    (ovf),
    .unf_o    (unf)
  );

  qpc_irq u_irq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ovf_evt_i(ovf),
    .unf_evt_i(unf),
    .wr_ie_i  (wr_en_i && wr_addr_i == ADDR_IE),
    .wr_clr_i (wr_en_i && wr_addr_i == ADDR_CLR),
    .wr_data_i(wr_data_i[FLAG_W-1:0]),
    .flags_o  (flags_o),
    .irq_o    (irq_o)
  );

  p_no_count_disabled_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !(wr_en_i && wr_addr_i == ADDR_CNT)) |=> $stable(count_o));
endmodule

// File: tb/qpc_top_tb_top.sv
module qpc_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_r = 1'b0, b_r = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] count;
  logic [6:0]  flags;
  logic        irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  qpc_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .enc_a_i(a_r), .enc_b_i(b_r),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .count_o(count), .flags_o(flags), .irq_o(irq)
  );

  // {a, b, expected count}; quadrature mode, max = 5, start at 3 with ab = 00
  localparam logic [33:0] QTAB [8] = '{
    {2'b10, 32'd4}, {2'b11, 32'd5}, {2'b01, 32'd0}, {2'b00, 32'd1},
    {2'b01, 32'd0}, {2'b11, 32'd5}, {2'b10, 32'd4}, {2'b00, 32'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] addr, input logic [31:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic enc(input logic a, input logic b);
    @(negedge clk);
    a_r = a; b_r = b;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 count", count, 32'd0);
    chk("R1 flags", {25'd0, flags}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);

    // down mode, single edge; underflow from 0 exposes reset maximum
    wr(3'd2, 32'b1011);
    enc(1'b1, 1'b0);
    chk("R8 R1 wrap to reset max", count, 32'hFFFF_FFFF);
    chk("R8 unf flag, R10 no global", {25'd0, flags}, 32'h20);
    chk("R10 irq off when disabled", {31'd0, irq}, 32'd0);
    enc(1'b0, 1'b0);
    chk("R5 falling edge ignored at single rate", count, 32'hFFFF_FFFF);

    wr(3'd4, 32'h61);
    chk("R11 clear", {25'd0, flags}, 32'd0);

    wr(3'd1, 32'd5);
    wr(3'd0, 32'd3);
    chk("R9 accepted write", count, 32'd3);
    wr(3'd0, 32'd9);
    chk("R9 rejected write", count, 32'd3);

    // quadrature table
    wr(3'd2, 32'b1000);
    for (int i = 0; i < 8; i++) begin
      enc(QTAB[i][33], QTAB[i][32]);
      chk("R2 R7 R8 quadrature step", count, QTAB[i][31:0]);
    end
    chk("R7 R8 both flags", {25'd0, flags}, 32'h60);
    enc(1'b1, 1'b1);
    chk("R3 double change", count, 32'd3);
    enc(1'b0, 1'b0);
    chk("R3 double change back", count, 32'd3);

    // up mode, both edges, overflow interrupt enabled
    wr(3'd4, 32'h61);
    wr(3'd3, 32'h40);
    wr(3'd0, 32'd5);
    wr(3'd2, 32'b1110);
    enc(1'b1, 1'b0);
    chk("R7 overflow wrap", count, 32'd0);
    chk("R10 ovf + global", {25'd0, flags}, 32'h41);
    chk("R10 irq", {31'd0, irq}, 32'd1);
    enc(1'b0, 1'b0);
    chk("R5 falling edge at double rate", count, 32'd1);
    enc(1'b0, 1'b1);
    chk("R5 B ignored", count, 32'd1);
    wr(3'd4, 32'h41);
    chk("R11 clear global", {25'd0, flags}, 32'd0);
    chk("R11 irq drops", {31'd0, irq}, 32'd0);

    // pulse/direction
    wr(3'd2, 32'b1001);
    enc(1'b1, 1'b1);
    chk("R4 rising up", count, 32'd2);
    enc(1'b0, 1'b1);
    chk("R4 falling ignored", count, 32'd2);
    enc(1'b0, 1'b0);
    enc(1'b1, 1'b0);
    chk("R4 rising down", count, 32'd1);
    enc(1'b0, 1'b0);

    // disabled
    wr(3'd2, 32'b0001);
    enc(1'b1, 1'b1);
    chk("R6 disabled hold", count, 32'd1);
    enc(1'b0, 1'b1);
    chk("R6 disabled hold 2", count, 32'd1);

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule